// File: doc/BRIEF.md
# Strobe-Started Serial Frame Transmitter

This block turns a parallel byte into an asynchronous serial frame. A short pulse on a free-running strobe input captures the byte into a holding register on its rising edge and flips a request toggle. The baud-clock side sees that toggle change and raises a pending flag. Because of this, a strobe pulse much narrower than one baud period is never missed. All frame timing comes from the baud clock alone.

The sequencer is a chain of flipflops that carries a single one-bit token. A token enters the first stage only when the flag is pending and the whole chain is empty. While the token sits in that first stage, the output shift register takes the held byte on the next edge. The token then walks one stage per baud period while the line sends start, eight data bits (least significant first), even parity and stop. When the token reaches the final stage, the pending flag is dropped. A strobe that arrives while a frame is pending or in flight cannot be served, so it raises a sticky overrun flag.

Top module: `strobe_tx_ctrl`

## Requirements
- R1: While rst_n is low, tx_line_o is 1, tx_busy_o is 0 and tx_overrun_o is 0.
- R2: A strobe_i high pulse of 2 ns (shorter than one baud period) starts a frame. Count baud rising edges from the first edge after the strobe rising edge as edge 1. tx_busy_o is 0 after edge 3, rises at edge 4 and stays 1 through edge 15.
- R3: The line holds each frame bit for one baud period, starting at edge 5, in this order: start bit 0, data bits 0 to 7 least significant first, parity, stop bit 1.
- R4: The parity bit equals the XOR of the eight data bits (even parity).
- R5: tx_busy_o falls at edge 16, and tx_line_o is 1 whenever no frame is being sent.
- R6: The byte sent is the value of data_i at the strobe rising edge; changes on data_i after that edge do not alter the frame.
- R7: A strobe that arrives while a frame is pending or in progress sets tx_overrun_o. The frame in flight is sent unchanged, and no frame follows for the lost word.
- R8: tx_overrun_o stays 1 until ovr_clr_i is high at a baud edge. When a new overrun event and ovr_clr_i meet at the same edge, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_baud | input | 1 | Baud clock; one period per serial bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Asynchronous start strobe; its rising edge captures data_i |
| data_i | input | 8 | Parallel byte to send |
| ovr_clr_i | input | 1 | Synchronous clear for the overrun flag |
| tx_line_o | output | 1 | Serial line, idles high |
| tx_busy_o | output | 1 | High while the token is anywhere in the chain |
| tx_overrun_o | output | 1 | Sticky flag for a strobe that arrived too early |

## Verification
Two things can act on the overrun flag at the same baud edge: a new early strobe event that sets it, and the software clear. The bench starts a frame, then places a second strobe so that its synchronised event lands on the edge where ovr_clr_i is held high. It judges that the flag reads 1 after that edge and 0 after a later lone clear. A second overlap is a late strobe against the running token. There the bench confirms that the frame already loaded leaves the line unchanged and that no extra frame follows.

// File: rtl/tx_pkg.sv
package tx_pkg;
  localparam int TX_DATA_W   = 8;
  // start + parity + stop around the data field
  localparam int TX_OVERHEAD = 3;

  // token chain: one load stage plus one stage per frame bit
  function automatic int tx_stage_count(input int data_w);
    return data_w + TX_OVERHEAD + 1;
  endfunction
endpackage

// File: rtl/tx_strobe_capture.sv
module tx_strobe_capture #(
  parameter int DATA_W = 8
) (
  input  logic              strobe_i,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] hold_o,
  output logic              req_tgl_o
);
  logic [DATA_W-1:0] hold_q;
  logic              tgl_q;

  always_ff @(posedge strobe_i or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      tgl_q  <= 1'b0;
    end else begin
      hold_q <= data_i;
      tgl_q  <= ~tgl_q;
    end
  end

  assign hold_o    = hold_q;
  assign req_tgl_o = tgl_q;
endmodule

// File: rtl/tx_event_sync.sv
module tx_event_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_i,
  output logic rst_s_n,
  output logic evt_o
);
  localparam int SW = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [SW-1:0] rst_pipe_q;
  logic [SW-1:0] tgl_pipe_q;
  logic          tgl_seen_q;

  // reset: asserted at once, released through the pipe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SW-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[SW-1];

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      tgl_pipe_q <= '0;
      tgl_seen_q <= 1'b0;
    end else begin
      tgl_pipe_q <= {tgl_pipe_q[SW-2:0], tgl_i};
      tgl_seen_q <= tgl_pipe_q[SW-1];
    end
  end

  assign evt_o = tgl_pipe_q[SW-1] ^ tgl_seen_q;
endmodule

// File: rtl/tx_token_chain.sv
module tx_token_chain #(
  parameter int STAGES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pending_i,
  output logic [STAGES-1:0] chain_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  // injection only into an empty chain
  assign chain_d[0] = pending_i & ~(|chain_q);

  for (genvar g = 1; g < STAGES; g++) begin : g_step
    assign chain_d[g] = chain_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign chain_o = chain_q;
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              line_o
);
  localparam int FW = DATA_W + 3;

  logic [FW-1:0] sh_q;
  logic [FW-1:0] sh_d;
  logic [FW-1:0] frame_w;

  // LSB leaves first: start(0), data LSB..MSB, even parity, stop(1)
  assign frame_w = {1'b1, ^data_i, data_i, 1'b0};

  always_comb begin
    sh_d = sh_q;
    if (load_i)          sh_d = frame_w;
    else if (shift_en_i) sh_d = {1'b1, sh_q[FW-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign line_o = sh_q[0];
endmodule

// File: rtl/strobe_tx_ctrl.sv
module strobe_tx_ctrl #(
  parameter int DATA_W = tx_pkg::TX_DATA_W
) (
  input  logic              clk_baud,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ovr_clr_i,
  output logic              tx_line_o,
  output logic              tx_busy_o,
  output logic              tx_overrun_o
);
  localparam int STAGES = tx_pkg::tx_stage_count(DATA_W);

  logic [DATA_W-1:0] hold_w;
  logic              req_tgl_w;
  logic              rst_s_n;
  logic              evt_w;
  logic [STAGES-1:0] chain_q;
  logic              pending_q, pending_d;
  logic              ovr_q, ovr_d;
  logic              busy_w, last_w, shift_en_w;

  tx_strobe_capture #(.DATA_W(DATA_W)) u_cap (
    .strobe_i (strobe_i),
    .rst_n    (rst_n),
    .data_i   (data_i),
    .hold_o   (hold_w),
    .req_tgl_o(req_tgl_w)
  );

  tx_event_sync #(.SYNC_STAGES(2)) u_sync (
    .clk    (clk_baud),
    .rst_n  (rst_n),
    .tgl_i  (req_tgl_w),
    .rst_s_n(rst_s_n),
    .evt_o  (evt_w)
  );

  tx_token_chain #(.STAGES(STAGES)) u_chain (
    .clk      (clk_baud),
    .rst_n    (rst_s_n),
    .pending_i(pending_q),
    .chain_o  (chain_q)
  );

  assign busy_w     = |chain_q;
  assign last_w     = chain_q[STAGES-1];
  assign shift_en_w = |chain_q[STAGES-1:1];

  tx_frame_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk_baud),
    .rst_n     (rst_s_n),
    .load_i    (chain_q[0]),
    .shift_en_i(shift_en_w),
    .data_i    (hold_w),
    .line_o    (tx_line_o)
  );

  // pending: set by an event, dropped when the token leaves the last stage
  always_comb begin
    pending_d = pending_q;
    if (last_w)     pending_d = 1'b0;
    else if (evt_w) pending_d = 1'b1;
  end

  // overrun: a new event while pending or busy wins over the clear
  always_comb begin
    ovr_d = ovr_q;
    if (evt_w && (busy_w || pending_q)) ovr_d = 1'b1;
    else if (ovr_clr_i)                 ovr_d = 1'b0;
  end

  always_ff @(posedge clk_baud or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pending_q <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      pending_q <= pending_d;
      ovr_q     <= ovr_d;
    end
  end

  assign tx_busy_o    = busy_w;
  assign tx_overrun_o = ovr_q;
endmodule

// File: rtl/strobe_tx_ctrl_chk.sv
module strobe_tx_ctrl_chk #(
  parameter int STAGES = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [STAGES-1:0] chain,
  input logic              line,
  input logic              busy,
  input logic              overrun,
  input logic              clr
);
  // R2: at most one token in the chain
  p_single_token_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chain));

  // R2: a token in the load stage moves on and the load stage empties
  p_token_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chain[0] |=> (chain[1] && !chain[0]));

  // R3: the first bit time drives the start level
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chain[1] |-> !line);

  // R5: last bit time is the stop level
  p_stop_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chain[STAGES-1] |-> line);

  // R5: idle line is high
  p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line);

  // R8: the flag holds without a clear
  p_ovr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clr) |=> overrun);
endmodule

bind strobe_tx_ctrl strobe_tx_ctrl_chk #(.STAGES(STAGES)) u_chk (
  .clk    (clk_baud),
  .rst_n  (rst_s_n),
  .chain  (chain_q),
  .line   (tx_line_o),
  .busy   (tx_busy_o),
  .overrun(tx_overrun_o),
  .clr    (ovr_clr_i)
);

// File: tb/strobe_tx_ctrl_bench.sv
module strobe_tx_ctrl_bench;
  logic       clk_baud = 1'b0;
  logic       rst_n;
  logic       strobe_i;
  logic [7:0] data_i;
  logic       ovr_clr_i;
  logic       tx_line_o, tx_busy_o, tx_overrun_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  always #4 clk_baud = ~clk_baud;

  strobe_tx_ctrl u_strobe_tx_ctrl (
    .clk_baud    (clk_baud),
    .rst_n       (rst_n),
    .strobe_i    (strobe_i),
    .data_i      (data_i),
    .ovr_clr_i   (ovr_clr_i),
    .tx_line_o   (tx_line_o),
    .tx_busy_o   (tx_busy_o),
    .tx_overrun_o(tx_overrun_o)
  );

  // {expected parity, data}
  localparam logic [8:0] VEC [7] = '{
    {1'b0, 8'h00}, {1'b0, 8'hFF}, {1'b1, 8'h01}, {1'b0, 8'hA5},
    {1'b1, 8'h80}, {1'b0, 8'h7E}, {1'b1, 8'h37}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_strobe(input logic [7:0] d);
    data_i   = d;
    #1 strobe_i = 1'b1;
    #2 strobe_i = 1'b0;
    data_i   = ~d;  // R6: later changes must not matter
  endtask

  // one frame; optional early second strobe at bit index late_k
  task automatic run_frame(input logic [7:0] d, input logic p, input int late_k);
    logic exp_bit;
    @(posedge clk_baud);
    pulse_strobe(d);
    #1;
    repeat (3) @(posedge clk_baud);
    #4 chk("R2 busy low before edge4", tx_busy_o, 0);
    @(posedge clk_baud);
    #4 chk("R2 busy at edge4", tx_busy_o, 1);
    chk("R5 line high in load cycle", tx_line_o, 1);
    for (int k = 0; k < 11; k++) begin
      @(posedge clk_baud);
      #4;
      if (k == 0)       exp_bit = 1'b0;
      else if (k <= 8)  exp_bit = d[k-1];
      else if (k == 9)  exp_bit = p;
      else              exp_bit = 1'b1;
      if (k == 9) chk("R4 parity bit", tx_line_o, exp_bit);
      else        chk("R3 frame bit", tx_line_o, exp_bit);
      chk("R2 busy during frame", tx_busy_o, 1);
      if (k == late_k) pulse_strobe(~d);
    end
    @(posedge clk_baud);
    #4 chk("R5 busy low at edge16", tx_busy_o, 0);
    chk("R5 line idle high", tx_line_o, 1);
  endtask

  initial begin
    rst_n     = 1'b0;
    strobe_i  = 1'b0;
    data_i    = 8'h00;
    ovr_clr_i = 1'b0;
    repeat (3) @(posedge clk_baud);
    #4;
    chk("R1 line in reset", tx_line_o, 1);
    chk("R1 busy in reset", tx_busy_o, 0);
    chk("R1 overrun in reset", tx_overrun_o, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk_baud);
    #4 chk("R1 idle after release", tx_busy_o, 0);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < 7; i++) begin
      run_frame(VEC[i][7:0], VEC[i][8], -1);
      chk("R7 no overrun on clean frame", tx_overrun_o, 0);
    end

    // R7: early strobe during bit 3; frame intact, word dropped
    run_frame(8'h5C, 1'b0, 3);
    chk("R7 overrun set", tx_overrun_o, 1);
    for (int c = 0; c < 12; c++) begin
      @(posedge clk_baud);
      #4 chk("R7 lost word not sent", tx_busy_o, 0);
    end

    // R8: flag holds, then lone clear
    chk("R8 overrun held", tx_overrun_o, 1);
    @(posedge clk_baud);
    #1 ovr_clr_i = 1'b1;
    @(posedge clk_baud);
    #1 ovr_clr_i = 1'b0;
    #3 chk("R8 clear drops flag", tx_overrun_o, 0);

    // R8: event and clear at the same edge -> set wins
    @(posedge clk_baud);
    pulse_strobe(8'h3C);
    repeat (6) @(posedge clk_baud);
    #1;
    pulse_strobe(8'hC3);           // F0 is the edge just passed
    @(posedge clk_baud);           // F1
    @(posedge clk_baud);           // F2
    #1 chk("R8 flag low before clash", tx_overrun_o, 0);
    ovr_clr_i = 1'b1;
    @(posedge clk_baud);           // F3: event and clear together
    #1 ovr_clr_i = 1'b0;
    #3 chk("R8 set wins over clear", tx_overrun_o, 1);
    repeat (16) @(posedge clk_baud);
    #4 chk("R7 idle after clash frame", tx_busy_o, 0);

    // R1: reset in the middle of a frame
    @(posedge clk_baud);
    pulse_strobe(8'h96);
    repeat (8) @(posedge clk_baud);
    #4 rst_n = 1'b0;
    #1;
    chk("R1 busy after mid reset", tx_busy_o, 0);
    chk("R1 line after mid reset", tx_line_o, 1);
    chk("R1 overrun after mid reset", tx_overrun_o, 0);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk_baud);
    run_frame(8'h4B, 1'b0, -1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule